// File: doc/BRIEF.md
# Sample Clock Divider with Phase Slip

This block derives the converter's working clock from the incoming sample clock. The output runs at the input rate, half of it, or a quarter of it. After a hard reset the ratio comes from a board-strapped selection: a three-level pin, already decoded to two bits outside the block. A 3-bit control word written over the serial control path can replace that selection. The control word keeps its value through a soft reset. Only a hard reset hands the choice back to the pin.

Several converters can share one input clock and still come up with their divided clocks out of step. To align them, a phase-slip command pulls the next rising edge of the divided clock in by one input cycle. The command is a 0-to-1 change of a one-bit slip register. The bit is passed through a synchronizer and turned into a single pulse. Each pulse makes the counter skip one state. Successive commands add up.

There is no data stream here. Every input and output is a plain control or clock pin, and none uses a valid/ready handshake or back-pressure.

Top module: `sample_clk_divider`

## Requirements
- R1: A write of control code 3'b000, 3'b001 or 3'b010 selects divide by 1, 2 or 4 respectively and overrides the pin selection.
- R2: Control code 3'b100, and any code other than the three in R1, selects the pin path, where pin_div 2'b00 means divide by 1, 2'b01 divide by 2, and 2'b10 or 2'b11 divide by 4. A hard reset sets the code to 3'b100.
- R3: In divide by 2 and divide by 4 with no slip, every rising edge of clk_out is N input cycles after the previous one and stays high for N/2 cycles.
- R4: In divide by 1, clk_out equals clk_in, and a slip command leaves it unchanged.
- R5: A slip fires only when the slip bit (the 1-bit slip write data) goes from 0 to 1. Writing 1 while the bit is already 1 causes no slip, and each 0-to-1 transition causes exactly one slip.
- R6: In divide by 4, each slip moves every later rising edge one input cycle earlier. Two slips move them two cycles earlier.
- R7: In divide by 2, a slip shifts the rising-edge phase by one input cycle.
- R8: When the effective ratio changes to 2 or 4, the counter restarts and clk_out is high after the first clk_in edge that follows the edge on which the new ratio took effect. No high or low phase is ever shorter than one input cycle.
- R9: A soft reset drives clk_out low, clears the counter and the slip bit, and keeps the control code.
- R10: While hard reset is asserted and the ratio is 2 or 4, clk_out is low. clk_out rises on the first clk_in edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input sample clock |
| rst_n | input | 1 | Active-low hard reset, asynchronous |
| soft_rst | input | 1 | Synchronous soft reset; control code kept |
| pin_div | input | 2 | Decoded three-level pin ratio selection |
| div_wr_en | input | 1 | Write strobe for the ratio control code |
| div_wr_data | input | 3 | Ratio control code |
| slip_wr_en | input | 1 | Write strobe for the slip bit |
| slip_wr_data | input | 1 | New value of the slip bit |
| clk_out | output | 1 | Divided clock |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This shows that slip results do not depend on synchronizer latency. Phase is measured only after a settling window, against a reference edge taken from clk_out itself. That reference makes it possible to check a single slip, accumulated slips, the ignored 1-to-1 rewrite, and the restart after a ratio change in both divided modes. The pin is left on a ratio different from the one that was written, so soft and hard reset give clearly different results.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    RATIO_1    = 2'b00,
    RATIO_2    = 2'b01,
    RATIO_4    = 2'b10,
    RATIO_NONE = 2'b11
  } ratio_e;

  localparam int          CODE_W   = 3;
  localparam int          CNT_W    = 2;
  localparam logic [2:0]  CODE_D1  = 3'b000;
  localparam logic [2:0]  CODE_D2  = 3'b001;
  localparam logic [2:0]  CODE_D4  = 3'b010;
  localparam logic [2:0]  CODE_PIN = 3'b100;
endpackage

// File: rtl/clkdiv_ratio_sel.sv
module clkdiv_ratio_sel
  import clkdiv_pkg::*;
#(
  parameter int PIN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [PIN_W-1:0]  pin_sel,
  output ratio_e            ratio
);
  logic [CODE_W-1:0] ctl_q;
  ratio_e            pin_ratio;

  // hard reset only; soft reset deliberately absent
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= CODE_PIN;
    else if (wr_en) ctl_q <= wr_data;
  end

  always_comb begin
    unique case (pin_sel[1:0])
      2'b00:   pin_ratio = RATIO_1;
      2'b01:   pin_ratio = RATIO_2;
      default: pin_ratio = RATIO_4;
    endcase
  end

  always_comb begin
    case (ctl_q)
      CODE_D1: ratio = RATIO_1;
      CODE_D2: ratio = RATIO_2;
      CODE_D4: ratio = RATIO_4;
      default: ratio = pin_ratio;
    endcase
  end

  // R9: soft reset leaves the control code untouched
  a_r9_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !wr_en) |=> $stable(ctl_q));
endmodule

// File: rtl/clkdiv_slip_det.sv
module clkdiv_slip_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic wr_en,
  input  logic wr_bit,
  output logic slip_pulse
);
  logic              slip_bit;
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = slip_bit;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], slip_bit};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slip_bit <= 1'b0;
      sync_q   <= '0;
      last_q   <= 1'b0;
    end else if (soft_rst) begin
      slip_bit <= 1'b0;
      sync_q   <= '0;
      last_q   <= 1'b0;
    end else begin
      if (wr_en) slip_bit <= wr_bit;
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign slip_pulse = sync_q[STAGES-1] & ~last_q;

  // R5: one transition yields a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |=> !slip_pulse);
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   soft_rst,
  input  ratio_e ratio,
  input  logic   slip,
  output logic   div_q
);
  ratio_e           ratio_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] half_v;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    case (ratio_q)
      RATIO_2: begin mask = CNT_W'(1); half_v = CNT_W'(1); end
      RATIO_4: begin mask = CNT_W'(3); half_v = CNT_W'(2); end
      default: begin mask = '0;        half_v = '0;        end
    endcase
    step   = slip ? CNT_W'(2) : CNT_W'(1);
    cnt_nx = (cnt + step) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RATIO_NONE;
      cnt     <= '0;
      div_q   <= 1'b0;
    end else if (soft_rst) begin
      ratio_q <= RATIO_NONE;
      cnt     <= '0;
      div_q   <= 1'b0;
    end else if (ratio != ratio_q) begin
      ratio_q <= ratio;
      cnt     <= '0;
      div_q   <= (ratio != RATIO_1);
    end else begin
      cnt     <= cnt_nx;
      div_q   <= (cnt_nx < half_v);
    end
  end

  // R7: half-rate counter never leaves its two states
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q == RATIO_2) |-> (cnt <= CNT_W'(1)));

  // R3: without a slip, a quarter-rate high phase lasts at least two cycles
  a_r3_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q == RATIO_4 && ratio == RATIO_4 && $rose(div_q) && !slip &&
     !$past(slip) && !soft_rst) |=> div_q);

  // R8: a change to a divided ratio restarts with a high phase
  a_r8_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != ratio_q && ratio != RATIO_1 && !soft_rst) |=> (div_q && cnt == '0));
endmodule

// File: rtl/sample_clk_divider.sv
module sample_clk_divider
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PIN_W       = 2
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [PIN_W-1:0]  pin_div,
  input  logic              div_wr_en,
  input  logic [CODE_W-1:0] div_wr_data,
  input  logic              slip_wr_en,
  input  logic              slip_wr_data,
  output logic              clk_out
);
  ratio_e ratio;
  logic   slip_pulse;
  logic   div_q;

  clkdiv_ratio_sel #(.PIN_W(PIN_W)) u_sel (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .wr_en    (div_wr_en),
    .wr_data  (div_wr_data),
    .pin_sel  (pin_div),
    .ratio    (ratio)
  );

  clkdiv_slip_det #(.STAGES(SYNC_STAGES)) u_slip (
    .clk        (clk_in),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .wr_en      (slip_wr_en),
    .wr_bit     (slip_wr_data),
    .slip_pulse (slip_pulse)
  );

  clkdiv_core u_core (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .ratio    (ratio),
    .slip     (slip_pulse),
    .div_q    (div_q)
  );

  assign clk_out = (ratio == RATIO_1) ? clk_in : div_q;
endmodule

// File: tb/sample_clk_divider_tb_top.sv
module sample_clk_divider_tb_top;
  typedef struct {
    int    n;
    int    phase;
    int    high;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic [1:0] pin_div = 2'b10;
  logic       div_wr_en = 1'b0;
  logic [2:0] div_wr_data = 3'b000;
  logic       slip_wr_en = 1'b0;
  logic       slip_wr_data = 1'b0;
  logic       clk_out;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   ref_cyc = 0;
  int   last_rise = 0;
  exp_t exp_q[$];
  exp_t cur;
  bit   pend = 0;
  int   hw = 0;
  logic prev_out = 1'b0;
  event ev_rise;

  always #4 clk = ~clk;

  sample_clk_divider #(.SYNC_STAGES(3)) dut_i (
    .clk_in       (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .pin_div      (pin_div),
    .div_wr_en    (div_wr_en),
    .div_wr_data  (div_wr_data),
    .slip_wr_en   (slip_wr_en),
    .slip_wr_data (slip_wr_data),
    .clk_out      (clk_out)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items at each rising edge of clk_out
  always @(negedge clk) begin
    if (clk_out && !prev_out) begin
      last_rise = cyc;
      if (exp_q.size() > 0) begin
        int ph;
        cur = exp_q.pop_front();
        ph  = (cyc - ref_cyc) % cur.n;
        checks++;
        if (ph != cur.phase) begin
          errors++;
          $display("FAIL %s phase: actual %0d expected %0d", cur.tag, ph, cur.phase);
        end
        pend = 1;
      end else pend = 0;
      hw = 1;
      ->ev_rise;
    end else if (clk_out) begin
      hw++;
    end else if (prev_out && pend) begin
      checks++;
      if (hw != cur.high) begin
        errors++;
        $display("FAIL %s high width: actual %0d expected %0d", cur.tag, hw, cur.high);
      end
      pend = 0;
    end
    prev_out = clk_out;
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr_div(input logic [2:0] v);
    @(negedge clk); div_wr_en = 1'b1; div_wr_data = v;
    @(negedge clk); div_wr_en = 1'b0;
  endtask

  task automatic wr_slip(input logic b);
    @(negedge clk); slip_wr_en = 1'b1; slip_wr_data = b;
    @(negedge clk); slip_wr_en = 1'b0;
  endtask

  task automatic set_ref();
    repeat (12) @(negedge clk);
    @(ev_rise);
    ref_cyc = last_rise;
  endtask

  // driver side of the scoreboard
  task automatic expect_rises(input int cnt, input int n, input int ph, input string tag);
    for (int i = 0; i < cnt; i++) begin
      exp_t e;
      e.n = n; e.phase = ph; e.high = n / 2; e.tag = tag;
      exp_q.push_back(e);
    end
    while (exp_q.size() != 0 || pend) @(negedge clk);
  endtask

  task automatic check_pass(input string tag);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2; check(tag, clk_out, 1'b1);
      @(negedge clk); #2; check(tag, clk_out, 1'b0);
    end
  endtask

  task automatic run_tests();
    // R10: low in reset, rises at first edge after release
    repeat (3) @(negedge clk);
    check("R10 reset low", clk_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 first rise", clk_out, 1'b1);

    // R2 / R3: pin selects divide by 4
    set_ref();
    expect_rises(4, 4, 0, "R3 div4 pin");

    // R5 / R6: one slip advances by one cycle
    wr_slip(1'b0); wr_slip(1'b1);
    expect_rises(0, 4, 0, "");
    repeat (12) @(negedge clk);
    expect_rises(3, 4, 3, "R6 single slip");

    // R5: rewrite of 1 does nothing
    wr_slip(1'b1);
    repeat (12) @(negedge clk);
    expect_rises(3, 4, 3, "R5 no slip on 1 to 1");

    // R6: second slip accumulates
    wr_slip(1'b0); wr_slip(1'b1);
    repeat (12) @(negedge clk);
    expect_rises(3, 4, 2, "R6 two slips");

    // R1 / R8: register override to divide by 2 restarts high
    wr_div(3'b001);
    @(negedge clk);
    check("R8 restart high", clk_out, 1'b1);
    set_ref();
    expect_rises(4, 2, 0, "R1 div2 register");

    // R7: slip in divide by 2
    wr_slip(1'b0); wr_slip(1'b1);
    repeat (12) @(negedge clk);
    expect_rises(3, 2, 1, "R7 div2 slip");

    // R9: soft reset keeps the code, clears the slip bit
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R9 soft reset low", clk_out, 1'b0);
    set_ref();
    expect_rises(3, 2, 0, "R9 code kept");
    wr_slip(1'b1);
    repeat (12) @(negedge clk);
    expect_rises(3, 2, 1, "R9 slip bit cleared");

    // R2: unused code falls back to the pin (divide by 4)
    wr_div(3'b011);
    set_ref();
    expect_rises(3, 4, 0, "R2 unused code");

    // R4: divide by 1 passes the clock, slip ignored
    wr_div(3'b000);
    repeat (4) @(negedge clk);
    check_pass("R4 div1");
    wr_slip(1'b0); wr_slip(1'b1);
    repeat (12) @(negedge clk);
    check_pass("R4 div1 after slip");

    // R2: explicit pin code with pin at divide by 2
    pin_div = 2'b01;
    wr_div(3'b100);
    set_ref();
    expect_rises(3, 2, 0, "R2 pin code");

    // R2: hard reset returns to pin control
    wr_div(3'b010);
    pin_div = 2'b00;
    set_ref();
    expect_rises(2, 4, 0, "R1 div4 register");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_pass("R2 hard reset to pin");
    pin_div = 2'b01;
    set_ref();
    expect_rises(3, 2, 0, "R2 pin after hard reset");
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule